// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit timer that counts in a triangle: it climbs from zero to the top value 255 and then falls back to zero, over and over. One PWM output is built from a compare value. On the way up, a match sets the output. On the way down, a match clears it. The result is a centre-aligned waveform whose duty cycle is set by the compare value. One full period is 510 counter steps long.

A prescaler sits in front of the counter. It turns the system clock into a step enable that fires once every 1, 8, 64, 256 or 1024 clocks. Everything, the prescaler included, runs on the one system clock.

Software reaches the block through a small write port:

- Address 0 holds the compare value. The value written there is staged in a buffer and only takes effect when the counter lands on the top.
- Address 1 holds control. Bit 0 is enable, bits 3:1 are the prescale code and bit 4 is output inversion.
- Address 2 is the flag-clear address.

The counter's direction is a two-state machine. State COUNT_UP has one transition: when a step lands on 255 it moves to COUNT_DOWN. State COUNT_DOWN has one transition: when a step lands on 0 it moves back to COUNT_UP. At each turning point the output is forced to the level that keeps the waveform symmetric, so the output stays correct even when a compare match is skipped.

Top module: `pcpwm_timer`

## Requirements
- R1: A synchronous reset puts the block in this state: counter 0, direction COUNT_UP, active and buffered compare 0, output logic 0 (non-inverted), flag 0, enable off, prescale code 0.
- R2: While enable is 1, the counter takes one step every N clocks. The prescale code selects N as follows: 0 gives 1, 1 gives 8, 2 gives 64, 3 gives 256, and 4 to 7 give 1024. A 10-bit prescale count runs from 0 up to N-1, and a step fires in the clock where it equals N-1. While enable is 0, the counter holds and the prescale count returns to 0.
- R3: Counting up, the steps run 0, 1, …, 254, 255. Counting down, they run 254, …, 1, 0. The direction reverses on landing at 255 and on landing at 0, so one period is 510 steps.
- R4: A step up that lands on the active compare value sets the raw output to 1. A step down that lands on it clears the raw output to 0.
- R5: With an active compare value of 0, the raw output is 0 at all times.
- R6: With an active compare value of 255, the raw output is 1 at all times.
- R7: Two levels are forced at the turning points, whether or not a match occurs. On landing at 255, the raw output becomes 1 if the new active compare value is nonzero, and 0 otherwise. On landing at 0, the raw output becomes 1 only if the active compare value is 255. This covers a match missed because the counter is already above the compare value, and a move away from the top value.
- R8: A write to address 0 only loads the buffer. The active compare value takes the buffer's value in the step that lands on 255, and changes at no other time.
- R9: pwm_out equals the raw output XOR control bit 4. A change to the inversion bit shows on the output in the clock after the write.
- R10: A step down that lands on 0 sets the flag. The flag then stays set until a write to address 2 with data bit 0 equal to 1. A write there with bit 0 equal to 0 does nothing. If a set and a clear fall in the same clock, the set wins.
- R11: A write to address 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 compare, 1 control, 2 flag clear |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM waveform, after the polarity setting |
| count_out | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky flag, set when the counter reaches bottom |

## Verification
A wrong direction state shows up on count_out at the very next step: the counter moves the wrong way or steps past 255 or below 0. A stale or wrongly loaded active compare value corrupts the duty cycle within one period. A missing forced level at a turning point puts the wrong output level on the pin in the same step that lands on 0 or 255. A wrong prescale count shifts when the count changes by at least one clock in every step. For these reasons the bench checks count, output and flag against a reference model every clock. The random phases change the compare value mid-period so that missed matches and loads at the top occur often.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic {
        COUNT_UP   = 1'b0,
        COUNT_DOWN = 1'b1
    } dir_e;

    localparam logic [1:0] ADDR_CMP  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_LSB = 1;
    localparam int CTRL_SEL_W   = 3;
    localparam int CTRL_INV_BIT = 4;

    // log2 of the division factor for each prescale code
    function automatic int unsigned presc_shift(input logic [CTRL_SEL_W-1:0] sel);
        int unsigned sh;
        case (sel)
            3'd0:    sh = 0;
            3'd1:    sh = 3;
            3'd2:    sh = 6;
            3'd3:    sh = 8;
            default: sh = 10;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
    import pcpwm_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [CTRL_SEL_W-1:0] sel,
    output logic                  tick
);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;

    always_comb begin
        pre_lim = PRE_W'((32'd1 << presc_shift(sel)) - 32'd1);
        tick    = enable && (pre_cnt == pre_lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_ONE;
        end
    end

endmodule

// File: rtl/pcpwm_regs.sv
module pcpwm_regs
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  flag_set,
    output logic [CNT_W-1:0]      cmp_buf,
    output logic                  enable,
    output logic [CTRL_SEL_W-1:0] sel,
    output logic                  invert,
    output logic                  flag
);
    logic wr_cmp;
    logic wr_ctrl;
    logic wr_clr;

    always_comb begin
        wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_clr  = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_buf <= '0;
            enable  <= 1'b0;
            sel     <= '0;
            invert  <= 1'b0;
        end else begin
            if (wr_cmp) begin
                cmp_buf <= wr_data;
            end
            if (wr_ctrl) begin
                enable <= wr_data[CTRL_EN_BIT];
                sel    <= wr_data[CTRL_SEL_LSB +: CTRL_SEL_W];
                invert <= wr_data[CTRL_INV_BIT];
            end
        end
    end

    // set has priority over a software clear in the same clock
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (flag_set) begin
            flag <= 1'b1;
        end else if (wr_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             step_up,
    output logic             hit_top,
    output logic             hit_bottom
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP     = '1;
    localparam logic [CNT_W-1:0] TOP_M1  = TOP - ONE;

    dir_e dir_nxt;

    // next-state and next-count
    always_comb begin
        dir_nxt = dir;
        cnt_nxt = cnt;
        if (tick) begin
            unique case (dir)
                COUNT_UP: begin
                    cnt_nxt = cnt + ONE;
                    if (cnt == TOP_M1) begin
                        dir_nxt = COUNT_DOWN;
                    end
                end
                COUNT_DOWN: begin
                    cnt_nxt = cnt - ONE;
                    if (cnt == ONE) begin
                        dir_nxt = COUNT_UP;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= COUNT_UP;
            cnt <= '0;
        end else begin
            dir <= dir_nxt;
            cnt <= cnt_nxt;
        end
    end

    // step events seen by the waveform stage
    always_comb begin
        step_up    = 1'b0;
        hit_top    = 1'b0;
        hit_bottom = 1'b0;
        unique case (dir)
            COUNT_UP: begin
                step_up = 1'b1;
                hit_top = tick && (cnt == TOP_M1);
            end
            COUNT_DOWN: begin
                hit_bottom = tick && (cnt == ONE);
            end
        endcase
    end

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             step_up,
    input  logic             hit_top,
    input  logic             hit_bottom,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic             invert,
    output logic [CNT_W-1:0] cmp_act,
    output logic             raw,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act <= '0;
            raw     <= 1'b0;
        end else if (tick) begin
            if (hit_top) begin
                // reload and force the level of an up-count match
                cmp_act <= cmp_buf;
                raw     <= (cmp_buf != '0);
            end else if (hit_bottom) begin
                raw <= (cmp_act == TOP);
            end else if (cnt_nxt == cmp_act) begin
                raw <= step_up;
            end
        end
    end

    assign pwm = raw ^ invert;

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_out,
    output logic             ovf_flag
);
    logic                  tick;
    logic                  enable;
    logic [CTRL_SEL_W-1:0] sel;
    logic                  invert;
    logic [CNT_W-1:0]      cmp_buf;
    logic [CNT_W-1:0]      cmp_act;
    logic [CNT_W-1:0]      cnt;
    logic [CNT_W-1:0]      cnt_nxt;
    dir_e                  dir;
    logic                  step_up;
    logic                  hit_top;
    logic                  hit_bottom;
    logic                  raw;

    pcpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .flag_set (hit_bottom),
        .cmp_buf  (cmp_buf),
        .enable   (enable),
        .sel      (sel),
        .invert   (invert),
        .flag     (ovf_flag)
    );

    pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .sel    (sel),
        .tick   (tick)
    );

    pcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cnt        (cnt),
        .dir        (dir),
        .cnt_nxt    (cnt_nxt),
        .step_up    (step_up),
        .hit_top    (hit_top),
        .hit_bottom (hit_bottom)
    );

    pcpwm_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .step_up    (step_up),
        .hit_top    (hit_top),
        .hit_bottom (hit_bottom),
        .cnt_nxt    (cnt_nxt),
        .cmp_buf    (cmp_buf),
        .invert     (invert),
        .cmp_act    (cmp_act),
        .raw        (raw),
        .pwm        (pwm_out)
    );

    assign count_out = cnt;

endmodule

// File: rtl/pcpwm_timer_sva.sv
module pcpwm_timer_sva
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input dir_e             dir,
    input logic             raw,
    input logic [CNT_W-1:0] cmp_act,
    input logic             ovf
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (((cnt - $past(cnt)) == ONE) || (($past(cnt) - cnt) == ONE)));

    a_r3_top_turns_down: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |-> (dir == COUNT_DOWN));

    a_r3_bottom_turns_up: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> (dir == COUNT_UP));

    a_r5_zero_low: assert property (@(posedge clk) disable iff (rst)
        (cmp_act == '0) |-> !raw);

    a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
        (cmp_act == TOP) |-> raw);

    a_r7_top_level: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |-> (raw == (cmp_act != '0)));

    a_r7_bottom_level: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && ($past(cnt) != '0)) |-> (raw == (cmp_act == TOP)));

    a_r8_load_at_top: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_act) |-> (cnt == TOP));

    a_r10_flag_at_bottom: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (cnt == '0));

endmodule

bind pcpwm_timer pcpwm_timer_sva #(.CNT_W(CNT_W)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (cnt),
    .dir     (dir),
    .raw     (raw),
    .cmp_act (cmp_act),
    .ovf     (ovf_flag)
);

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;
    logic [7:0] count_out;
    logic       ovf_flag;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string pwm_tag = "R4";

    // reference model state
    int m_pre, m_cnt, m_act, m_buf, m_sel;
    bit m_up, m_raw, m_en, m_inv, m_ovf;

    pcpwm_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out),
        .count_out (count_out),
        .ovf_flag  (ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int divisor(input int sel);
        case (sel)
            0: return 1;
            1: return 8;
            2: return 64;
            3: return 256;
            default: return 1024;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // model: R2 prescale, R3 sequence, R4/R7 levels, R8 load, R9/R10/R11 registers
    always @(posedge clk) begin
        bit tk, set_f, clr_f, raw_n, up_n;
        int n, act_n;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_act = 0; m_buf = 0; m_sel = 0;
            m_up = 1; m_raw = 0; m_en = 0; m_inv = 0; m_ovf = 0;
        end else begin
            tk = m_en && (m_pre == divisor(m_sel) - 1);
            set_f = 0; raw_n = m_raw; up_n = m_up; act_n = m_act; n = m_cnt;
            if (tk) begin
                if (m_up) begin
                    n = m_cnt + 1;
                    if (n == 255) begin
                        act_n = m_buf; raw_n = (m_buf != 0); up_n = 0;
                    end else if (n == m_act) raw_n = 1;
                end else begin
                    n = m_cnt - 1;
                    if (n == 0) begin
                        raw_n = (m_act == 255); up_n = 1; set_f = 1;
                    end else if (n == m_act) raw_n = 0;
                end
            end
            if (!m_en || tk) m_pre = 0;
            else m_pre = (m_pre + 1) % 1024;
            m_cnt = n; m_up = up_n; m_act = act_n; m_raw = raw_n;
            clr_f = 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_buf = wr_data;
                    2'd1: begin
                        m_en = wr_data[0]; m_sel = wr_data[3:1]; m_inv = wr_data[4];
                    end
                    2'd2: clr_f = wr_data[0];
                    default: ;
                endcase
            end
            if (set_f) m_ovf = 1;
            else if (clr_f) m_ovf = 0;
        end
    end

    // every-clock comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check("R3", int'(count_out), m_cnt, "count");
            check(pwm_tag, int'(pwm_out), int'(m_raw ^ m_inv), "pwm");
            check("R10", int'(ovf_flag), int'(m_ovf), "flag");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int highs, held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", int'(count_out), 0, "count after reset");
        check("R1", int'(pwm_out), 0, "pwm after reset");
        check("R1", int'(ovf_flag), 0, "flag after reset");
        chk_on = 1'b1;

        // R4: mid-range duty, N=1
        pwm_tag = "R4";
        wr(2'd0, 8'd100);
        wr(2'd1, 8'h01);
        run(1200);

        // R5: compare 0 gives a flat low output
        pwm_tag = "R5";
        wr(2'd0, 8'd0);
        run(600);
        count_high(510, highs);
        check("R5", highs, 0, "high clocks with compare 0");

        // R6: compare 255 gives a flat high output
        pwm_tag = "R6";
        wr(2'd0, 8'd255);
        run(600);
        count_high(510, highs);
        check("R6", highs, 510, "high clocks with compare 255");

        // R7: leaving the top value, then a value below the count
        pwm_tag = "R7";
        wr(2'd0, 8'd40);
        run(700);
        wr(2'd0, 8'd0);
        run(700);
        wr(2'd0, 8'd250);
        run(700);

        // R9: inversion applied immediately
        pwm_tag = "R9";
        wr(2'd1, 8'h11);
        check("R9", int'(pwm_out), int'(~m_raw & 1'b1), "inverted level");
        run(600);
        wr(2'd1, 8'h01);

        // R10: clear with bit0 = 0 ignored, with bit0 = 1 clears
        run(520);
        check("R10", int'(ovf_flag), 1, "flag set after bottom");
        wr(2'd2, 8'hFE);
        check("R10", int'(ovf_flag), 1, "flag kept on clear without bit0");
        wr(2'd2, 8'h01);
        check("R10", int'(ovf_flag), int'(m_ovf), "flag after clear");

        // R11: address 3 writes change nothing
        pwm_tag = "R11";
        wr(2'd3, 8'hFF);
        run(600);

        // R2: prescaled stepping and hold while disabled
        pwm_tag = "R2";
        wr(2'd1, 8'h03);
        run(4300);
        wr(2'd1, 8'h05);
        run(2000);
        wr(2'd1, 8'h00);
        held = int'(count_out);
        run(300);
        check("R2", int'(count_out), held, "count held while disabled");
        wr(2'd1, 8'h0F);
        run(3000);
        wr(2'd1, 8'h01);

        // R8: random compare writes mid-period
        pwm_tag = "R8";
        for (int i = 0; i < 24; i++) begin
            int v;
            v = $urandom_range(0, 9);
            if (v == 0) wr(2'd0, 8'd0);
            else if (v == 1) wr(2'd0, 8'd255);
            else wr(2'd0, 8'($urandom_range(0, 255)));
            if ($urandom_range(0, 3) == 0) wr(2'd1, {3'b000, 1'($urandom_range(0, 1)), 4'b0001});
            run($urandom_range(60, 800));
        end

        chk_on = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule